// File: doc/BRIEF.md
# Dual-Port Register File with Address-Latched Secondary Port

This block holds a bank of sixteen 8-bit registers and offers two ways in. The primary port has a 4-bit register index and a read/write level. It reads through a combinational data output. When the level is low, it writes on the clock edge.

The secondary port is an 8-bit data path that works in two steps. It is split at the block edge into an input, an output and an output enable, and the pad cell makes the bus tristate. In the first step, an address cycle captures the bus value as a register address. A status latch records whether that address falls inside the window 0x30 to 0x3F (060 to 077 octal). The low four bits of the address pick the register. In the second step, data cycles read or write the selected register, but only while the latch is set.

Secondary commands are qualified by an active-low enable, a select command, a write command and a master-clock level. All of these are sampled on the system clock. When both ports write the same register in one cycle, the primary write wins. No other conflict is flagged or resolved.

Top module: `regfile_dp`

## Requirements
- R1: While rst_ni is low, the captured address, the status latch and all sixteen registers are zero and sec_oe_o is low.
- R2: An address cycle (sec_en_ni=0, sec_sc_i=1, sec_wc_i=0, mclk_i=1) at a clock edge captures sec_d_i. The status latch becomes 1 if sec_d_i[7:4]==4'h3 and 0 otherwise. sec_d_i[3:0] selects the register.
- R3: While the status latch is 0, sec_oe_o stays low and no secondary write changes any register.
- R4: With sec_en_ni=0, sec_sc_i=0, sec_wc_i=0 and the latch set, sec_oe_o is high in the same cycle. sec_d_o then shows the selected register, whatever the level of mclk_i.
- R5: With sec_en_ni=0, sec_wc_i=1, sec_sc_i=0, mclk_i=1 and the latch set, sec_d_i is written into the selected register at the clock edge.
- R6: If pri_rw_i=0 and pri_addr_i equals the selected register in a secondary write cycle, the register takes pri_wdata_i and the secondary data is dropped.
- R7: A secondary write to one register and a primary write to a different register in the same cycle both take effect.
- R8: With sec_en_ni=1, or with a command present while mclk_i=0, the address, the latch and the registers are left untouched by the secondary port.
- R9: pri_rdata_o shows register pri_addr_i combinationally. With pri_rw_i=0, pri_wdata_i is written into that register at the clock edge.
- R10: sec_oe_o is low in every cycle that is not a secondary read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pri_addr_i | input | 4 | Primary register index |
| pri_rw_i | input | 1 | Primary level: 1 read, 0 write |
| pri_wdata_i | input | 8 | Primary write data |
| pri_rdata_o | output | 8 | Primary read data |
| sec_en_ni | input | 1 | Secondary enable, active low |
| sec_sc_i | input | 1 | Select command (address cycle) |
| sec_wc_i | input | 1 | Write command (data cycle) |
| mclk_i | input | 1 | Master-clock qualifier level |
| sec_d_i | input | 8 | Secondary bus, inbound |
| sec_d_o | output | 8 | Secondary bus, outbound (zero when not driving) |
| sec_oe_o | output | 1 | Secondary bus drive enable |

## Verification
The properties assume that the select and write commands are never high together, since that combination has no defined outcome. The random stimulus draws its command from a set of patterns that excludes that pair. Within that limit, the enable, master-clock level, primary level and index, and bus value are all random. Bus values lean towards the address window so that the latch is set often, and primary reads outnumber writes so that written data survives long enough to be read back. Directed cases cover the window edges, same-register and different-register collisions, and commands gated off by the enable or by a low master clock.

// File: rtl/regfile_dp_pkg.sv
package regfile_dp_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_ADDR  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } sec_op_e;

  // address lies in the aligned window whose upper bits match base
  function automatic logic in_window(input logic [7:0] addr,
                                     input logic [7:0] base,
                                     input int unsigned aw);
    return (addr >> aw) == (base >> aw);
  endfunction

endpackage

// File: rtl/regfile_dp_sec_ctrl.sv
module regfile_dp_sec_ctrl
  import regfile_dp_pkg::*;
#(
  parameter int unsigned BUS_W   = 8,
  parameter int unsigned AW      = 4,
  parameter logic [7:0]  WIN_BASE = 8'h30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_ni,
  input  logic             sc_i,
  input  logic             wc_i,
  input  logic             mclk_i,
  input  logic [BUS_W-1:0] bus_i,
  output logic [AW-1:0]    sel_o,
  output logic             latch_o,
  output logic             wr_o,
  output logic             rd_o
);

  sec_op_e op;
  logic [BUS_W-1:0] addr_q;
  logic             latch_q;

  always_comb begin
    op = OP_IDLE;
    if (!en_ni) begin
      unique case ({sc_i, wc_i})
        2'b10:   if (mclk_i) op = OP_ADDR;
        2'b01:   if (mclk_i && latch_q) op = OP_WRITE;
        2'b00:   if (latch_q) op = OP_READ;
        default: op = OP_IDLE; // both commands high: undefined, stay quiet
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      latch_q <= 1'b0;
    end else if (op == OP_ADDR) begin
      addr_q  <= bus_i;
      latch_q <= in_window(8'(bus_i), WIN_BASE, AW);
    end
  end

  assign sel_o   = addr_q[AW-1:0];
  assign latch_o = latch_q;
  assign wr_o    = (op == OP_WRITE);
  assign rd_o    = (op == OP_READ);

endmodule

// File: rtl/regfile_dp_bank.sv
module regfile_dp_bank #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NREGS  = 16,
  parameter int unsigned AW     = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         pw_en_i,
  input  logic [AW-1:0]                pw_addr_i,
  input  logic [DATA_W-1:0]            pw_data_i,
  input  logic                         sw_en_i,
  input  logic [AW-1:0]                sw_addr_i,
  input  logic [DATA_W-1:0]            sw_data_i,
  input  logic [AW-1:0]                pr_addr_i,
  output logic [DATA_W-1:0]            pr_data_o,
  input  logic [AW-1:0]                sr_addr_i,
  output logic [DATA_W-1:0]            sr_data_o,
  output logic [NREGS-1:0][DATA_W-1:0] bank_q_o
);

  logic [NREGS-1:0][DATA_W-1:0] q;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic pw_hit, sw_hit;
    assign pw_hit = pw_en_i && (pw_addr_i == AW'(g));
    assign sw_hit = sw_en_i && (sw_addr_i == AW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q[g] <= '0;
      else if (pw_hit) q[g] <= pw_data_i;   // primary wins a same-register clash
      else if (sw_hit) q[g] <= sw_data_i;
    end
  end

  assign pr_data_o = q[pr_addr_i];
  assign sr_data_o = q[sr_addr_i];
  assign bank_q_o  = q;

endmodule

// File: rtl/regfile_dp.sv
module regfile_dp #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NREGS    = 16,
  parameter logic [7:0]  WIN_BASE = 8'h30
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [$clog2(NREGS)-1:0]  pri_addr_i,
  input  logic                      pri_rw_i,
  input  logic [DATA_W-1:0]         pri_wdata_i,
  output logic [DATA_W-1:0]         pri_rdata_o,
  input  logic                      sec_en_ni,
  input  logic                      sec_sc_i,
  input  logic                      sec_wc_i,
  input  logic                      mclk_i,
  input  logic [DATA_W-1:0]         sec_d_i,
  output logic [DATA_W-1:0]         sec_d_o,
  output logic                      sec_oe_o
);

  localparam int unsigned AW = $clog2(NREGS);

  logic [AW-1:0]                sel_q;
  logic                         latch_q;
  logic                         sec_wr, sec_rd;
  logic [DATA_W-1:0]            sec_rdata;
  logic [NREGS-1:0][DATA_W-1:0] bank_q;

  regfile_dp_sec_ctrl #(
    .BUS_W   (DATA_W),
    .AW      (AW),
    .WIN_BASE(WIN_BASE)
  ) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_ni  (sec_en_ni),
    .sc_i   (sec_sc_i),
    .wc_i   (sec_wc_i),
    .mclk_i (mclk_i),
    .bus_i  (sec_d_i),
    .sel_o  (sel_q),
    .latch_o(latch_q),
    .wr_o   (sec_wr),
    .rd_o   (sec_rd)
  );

  regfile_dp_bank #(
    .DATA_W(DATA_W),
    .NREGS (NREGS),
    .AW    (AW)
  ) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pw_en_i  (!pri_rw_i),
    .pw_addr_i(pri_addr_i),
    .pw_data_i(pri_wdata_i),
    .sw_en_i  (sec_wr),
    .sw_addr_i(sel_q),
    .sw_data_i(sec_d_i),
    .pr_addr_i(pri_addr_i),
    .pr_data_o(pri_rdata_o),
    .sr_addr_i(sel_q),
    .sr_data_o(sec_rdata),
    .bank_q_o (bank_q)
  );

  assign sec_oe_o = sec_rd;
  assign sec_d_o  = sec_rd ? sec_rdata : '0;

endmodule

// File: rtl/regfile_dp_chk.sv
module regfile_dp_chk
  import regfile_dp_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NREGS    = 16,
  parameter logic [7:0]  WIN_BASE = 8'h30,
  localparam int unsigned AW      = $clog2(NREGS)
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         en_ni,
  input logic                         sc_i,
  input logic                         wc_i,
  input logic                         mclk_i,
  input logic [DATA_W-1:0]            d_i,
  input logic                         oe_o,
  input logic                         pri_rw_i,
  input logic [AW-1:0]                pri_addr_i,
  input logic [DATA_W-1:0]            pri_wdata_i,
  input logic [AW-1:0]                sel,
  input logic                         latch,
  input logic [NREGS-1:0][DATA_W-1:0] bank_q
);

  logic addr_cyc, wr_cyc, clash;
  assign addr_cyc = !en_ni && sc_i && !wc_i && mclk_i;
  assign wr_cyc   = !en_ni && wc_i && !sc_i && mclk_i && latch;
  assign clash    = !pri_rw_i && (pri_addr_i == sel);

  p_addr_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_cyc |=> latch == in_window(8'($past(d_i)), WIN_BASE, AW));

  p_addr_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_cyc |=> sel == $past(d_i[AW-1:0]));

  p_no_drive_unlatched_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch |-> !oe_o);

  p_drive_only_on_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> (!en_ni && !sc_i && !wc_i));

  p_sec_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cyc && !clash) |=> bank_q[$past(sel)] == $past(d_i));

  p_primary_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cyc && clash) |=> bank_q[$past(sel)] == $past(pri_wdata_i));

  p_inactive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_ni || !mclk_i) |=> ($stable(latch) && $stable(sel)));

  p_pri_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pri_rw_i |=> bank_q[$past(pri_addr_i)] == $past(pri_wdata_i));

endmodule

bind regfile_dp regfile_dp_chk #(
  .DATA_W  (DATA_W),
  .NREGS   (NREGS),
  .WIN_BASE(WIN_BASE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_ni      (sec_en_ni),
  .sc_i       (sec_sc_i),
  .wc_i       (sec_wc_i),
  .mclk_i     (mclk_i),
  .d_i        (sec_d_i),
  .oe_o       (sec_oe_o),
  .pri_rw_i   (pri_rw_i),
  .pri_addr_i (pri_addr_i),
  .pri_wdata_i(pri_wdata_i),
  .sel        (sel_q),
  .latch      (latch_q),
  .bank_q     (bank_q)
);

// File: tb/regfile_dp_test.sv
`timescale 1ns/1ps
module regfile_dp_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pri_addr = '0;
  logic       pri_rw = 1'b1;
  logic [7:0] pri_wdata = '0;
  logic [7:0] pri_rdata;
  logic       en_n = 1'b1, sc = 1'b0, wc = 1'b0, mclk = 1'b0;
  logic [7:0] d_in = '0;
  logic [7:0] d_out;
  logic       oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0] mem [16];
  logic [3:0] m_sel = '0;
  logic       m_latch = 1'b0;

  always #10 clk = ~clk;

  regfile_dp uut (
    .clk_i(clk), .rst_ni(rst_n),
    .pri_addr_i(pri_addr), .pri_rw_i(pri_rw), .pri_wdata_i(pri_wdata),
    .pri_rdata_o(pri_rdata),
    .sec_en_ni(en_n), .sec_sc_i(sc), .sec_wc_i(wc), .mclk_i(mclk),
    .sec_d_i(d_in), .sec_d_o(d_out), .sec_oe_o(oe)
  );

  function automatic bit exp_rd();
    return !en_n && !sc && !wc && m_latch;
  endfunction

  function automatic bit in_win(input logic [7:0] a);
    return a[7:4] == 4'h3;
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // one bus cycle: drive after negedge, check combinational outputs, update model at posedge
  task automatic step(input logic e, input logic s, input logic w, input logic m,
                      input logic [7:0] d, input logic prw, input logic [3:0] pa,
                      input logic [7:0] pwd, input string tag);
    string t_oe, t_rd, t_pr;
    @(negedge clk);
    en_n = e; sc = s; wc = w; mclk = m; d_in = d;
    pri_rw = prw; pri_addr = pa; pri_wdata = pwd;
    #2;
    t_oe = (tag != "") ? tag : exp_rd() ? "R4" : en_n ? "R8" : !m_latch ? "R3" : "R10";
    t_rd = (tag != "") ? tag : "R4";
    t_pr = (tag != "") ? tag : "R9";
    chk({7'd0, oe}, {7'd0, exp_rd()}, t_oe);
    if (exp_rd()) chk(d_out, mem[m_sel], t_rd);
    chk(pri_rdata, mem[pa], t_pr);
    @(posedge clk);
    if (!e && s && !w && m) begin
      m_sel = d[3:0];
      m_latch = in_win(d);
    end else if (!e && w && !s && m && m_latch) begin
      if (!(prw == 1'b0 && pa == m_sel)) mem[m_sel] = d;
    end
    if (prw == 1'b0) mem[pa] = pwd;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) mem[i] = '0;
    // R1: reset state
    repeat (2) @(posedge clk);
    en_n = 1'b0; sc = 1'b0; wc = 1'b0; mclk = 1'b1;
    #3;
    chk({7'd0, oe}, 8'd0, "R1");
    for (int i = 0; i < 16; i += 5) begin
      pri_addr = 4'(i);
      #1 chk(pri_rdata, 8'h00, "R1");
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R3: nothing latched yet, read and write blocked
    step(0, 0, 0, 1, 8'h00, 1, 4'd0, 8'h00, "R3");
    step(0, 0, 1, 1, 8'hAA, 1, 4'd0, 8'h00, "R3");
    step(0, 0, 0, 1, 8'h00, 1, 4'd0, 8'h00, "R3");
    // R2: window edges
    step(0, 1, 0, 1, 8'h2F, 1, 4'd0, 8'h00, "R2");
    step(0, 0, 0, 1, 8'h00, 1, 4'd0, 8'h00, "R2");
    step(0, 1, 0, 1, 8'h30, 1, 4'd0, 8'h00, "R2");
    step(0, 0, 0, 0, 8'h00, 1, 4'd0, 8'h00, "R2");
    step(0, 1, 0, 1, 8'h3F, 1, 4'd0, 8'h00, "R2");
    step(0, 0, 0, 1, 8'h00, 1, 4'd0, 8'h00, "R2");
    step(0, 1, 0, 1, 8'h40, 1, 4'd0, 8'h00, "R2");
    step(0, 0, 0, 1, 8'h00, 1, 4'd0, 8'h00, "R2");
    // R5: latched write then read back
    step(0, 1, 0, 1, 8'h35, 1, 4'd0, 8'h00, "R2");
    step(0, 0, 1, 1, 8'h5A, 1, 4'd0, 8'h00, "R5");
    step(0, 0, 0, 1, 8'h00, 1, 4'd5, 8'h00, "R5");
    // R6: same-register collision
    step(0, 0, 1, 1, 8'h22, 0, 4'd5, 8'h11, "R6");
    step(0, 0, 0, 1, 8'h00, 1, 4'd5, 8'h00, "R6");
    // R7: different registers both land
    step(0, 0, 1, 1, 8'h44, 0, 4'd9, 8'h33, "R7");
    step(0, 0, 0, 1, 8'h00, 1, 4'd9, 8'h00, "R7");
    // R8: gated-off commands
    step(1, 1, 0, 1, 8'h36, 1, 4'd0, 8'h00, "R8");
    step(0, 1, 0, 0, 8'h37, 1, 4'd0, 8'h00, "R8");
    step(0, 0, 1, 0, 8'h99, 1, 4'd0, 8'h00, "R8");
    step(1, 0, 1, 1, 8'h98, 1, 4'd0, 8'h00, "R8");
    step(0, 0, 0, 1, 8'h00, 1, 4'd5, 8'h00, "R8");

    // random traffic, never both commands high
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] c;
      logic [7:0] d;
      c = 2'($urandom_range(0, 2));
      d = ($urandom_range(0, 9) < 7) ? {4'h3, 4'($urandom)} : 8'($urandom);
      step(($urandom_range(0, 7) == 0), c == 2'd1, c == 2'd2, 1'($urandom),
           d, ($urandom_range(0, 3) != 0), 4'($urandom), 8'($urandom), "");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule